// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a processor front end that fetches 32-bit, fixed-length instructions. In each cycle it reads the current instruction word and the two source register values. From these it works out the address of the next instruction: the following word, a PC-relative conditional branch target, a region-absolute jump target, or a register-held address. When the advance strobe is high, the result is loaded into the PC register.

For call instructions, the block also produces a write request to the return-address register. The request carries the address of the instruction after the call, so the register file can record it in the same cycle the jump is taken. The design has no delay slot and no prediction, so each advance moves to exactly the address the current instruction selects.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, and directly after it is released, the PC equals RESET_PC (default 0) and the link write enable is low.
- R2: When advance is low, the PC keeps its value and the link write enable stays low, whatever the instruction is.
- R3: For an opcode (bits 31:26) that is not 6'h00, 6'h02, 6'h03, 6'h04 or 6'h05, an advance loads PC+4.
- R4: Opcode 6'h04 (branch-if-equal) loads PC+4 plus the sign-extended 16-bit field (bits 15:0) times four when rs_val equals rt_val, and loads PC+4 otherwise.
- R5: Opcode 6'h05 (branch-if-different) takes the same target when rs_val differs from rt_val, and loads PC+4 otherwise.
- R6: Branch offsets are signed, so a field with bit 15 set moves the PC backwards; the most negative field 16'h8000 reaches PC+4-0x20000.
- R7: Opcode 6'h02 (jump) loads {bits 31:28 of PC+4, the 26-bit field bits 25:0, 2'b00}.
- R8: Opcode 6'h03 (call) loads the same target as R7. In the advancing cycle it raises the link write enable, with link index 31 and link data equal to the current PC+4.
- R9: Opcode 6'h00 with function field (bits 5:0) 6'h08 (register jump) loads the full 32-bit rs_val.
- R10: Opcode 6'h00 with any other function field is sequential: PC+4, with no link write.
- R11: The upper four bits of a jump target come from PC+4, not PC. A jump at 0x0FFFFFFC therefore lands in the region starting at 0x10000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Load the next PC this cycle |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc | output | 32 | Registered program counter |
| link_we | output | 1 | Return-address write enable |
| link_idx | output | 5 | Return-address register index (31) |
| link_data | output | 32 | Value to write: current PC+4 |

## Verification
The hardest cases to reach are those that depend on the PC's upper bits. These are a jump made from the last word of a 256 MiB region, and a branch with the most negative offset, which needs a PC far from zero. A PC can only be changed through the block's own control flow. The stimulus therefore first uses a register jump to place the PC at 0x0FFFFFFC, then issues a jump so that PC+4 crosses into the next region. A maximal backward branch follows from that high address. A call executed with advance low checks that no stray link write occurs.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int OFF_W   = 16;
    localparam int IDX_W   = 26;
    localparam int RIDX_W  = 5;
    localparam int REGION_LSB = IDX_W + 2;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OP_JUMP    = 6'h02;
    localparam logic [OP_W-1:0] OP_CALL    = 6'h03;
    localparam logic [OP_W-1:0] OP_BREQ    = 6'h04;
    localparam logic [OP_W-1:0] OP_BRNE    = 6'h05;
    localparam logic [FN_W-1:0] FN_JREG    = 6'h08;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BREQ,
        FLOW_BRNE,
        FLOW_JUMP,
        FLOW_CALL,
        FLOW_JREG
    } flow_e;

    typedef struct packed {
        flow_e              flow;
        logic [OFF_W-1:0]   off;
        logic [IDX_W-1:0]   idx;
    } dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [OP_W-1:0] op;
    logic [FN_W-1:0] fn;

    assign op = instr[INSTR_W-1 -: OP_W];
    assign fn = instr[FN_W-1:0];

    always_comb begin
        dec.off  = instr[OFF_W-1:0];
        dec.idx  = instr[IDX_W-1:0];
        dec.flow = FLOW_SEQ;
        unique case (op)
            OP_BREQ:    dec.flow = FLOW_BREQ;
            OP_BRNE:    dec.flow = FLOW_BRNE;
            OP_JUMP:    dec.flow = FLOW_JUMP;
            OP_CALL:    dec.flow = FLOW_CALL;
            OP_SPECIAL: dec.flow = (fn == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:    dec.flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         same
);
    logic [W-1:0] diff;

    assign diff = a ^ b;
    assign same = ~|diff;
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic [IDX_W-1:0] idx,
    output logic [PC_W-1:0]  pc_inc,
    output logic [PC_W-1:0]  br_tgt,
    output logic [PC_W-1:0]  jmp_tgt
);
    localparam int EXT_W    = PC_W - OFF_W - 2;
    localparam int REGION_W = PC_W - REGION_LSB;

    logic [PC_W-1:0] off_bytes;

    assign pc_inc    = pc + PC_W'(4);
    assign off_bytes = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    assign br_tgt    = pc_inc + off_bytes;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_tgt = {pc_inc[PC_W-1 -: REGION_W], idx, 2'b00};
        end else begin : g_flat
            assign jmp_tgt = PC_W'({idx, 2'b00});
        end
    endgenerate
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int               PC_W     = 32,
    parameter logic [PC_W-1:0]  RESET_PC = '0,
    parameter logic [RIDX_W-1:0] LINK_REG = 5'd31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [31:0]       instr,
    input  logic [PC_W-1:0]   rs_val,
    input  logic [PC_W-1:0]   rt_val,
    output logic [PC_W-1:0]   pc,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [PC_W-1:0]   link_data
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } state_t;

    state_t st_d, st_q;

    dec_t            dec;
    logic            regs_same;
    logic [PC_W-1:0] pc_inc, br_tgt, jmp_tgt;
    logic            br_take;

    npc_decode #(.INSTR_W(32)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    npc_cmp #(.W(PC_W)) u_cmp (
        .a    (rs_val),
        .b    (rt_val),
        .same (regs_same)
    );

    npc_target #(.PC_W(PC_W)) u_tgt (
        .pc      (st_q.pc),
        .off     (dec.off),
        .idx     (dec.idx),
        .pc_inc  (pc_inc),
        .br_tgt  (br_tgt),
        .jmp_tgt (jmp_tgt)
    );

    always_comb begin
        st_d    = st_q;
        br_take = ((dec.flow == FLOW_BREQ) &&  regs_same) ||
                  ((dec.flow == FLOW_BRNE) && !regs_same);
        if (advance) begin
            unique case (dec.flow)
                FLOW_JUMP, FLOW_CALL: st_d.pc = jmp_tgt;
                FLOW_JREG:            st_d.pc = rs_val;
                FLOW_BREQ, FLOW_BRNE: st_d.pc = br_take ? br_tgt : pc_inc;
                default:              st_d.pc = pc_inc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc        = st_q.pc;
    assign link_we   = advance && (dec.flow == FLOW_CALL);
    assign link_idx  = LINK_REG;
    assign link_data = pc_inc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            advance,
    input logic [31:0]     instr,
    input logic [PC_W-1:0] rs_val,
    input logic [PC_W-1:0] rt_val,
    input logic [PC_W-1:0] pc,
    input logic            link_we,
    input logic [4:0]      link_idx,
    input logic [PC_W-1:0] link_data
);
    logic [5:0]      op;
    logic [5:0]      fn;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] br_pc;

    assign op     = instr[31:26];
    assign fn     = instr[5:0];
    assign seq_pc = pc + PC_W'(4);
    assign br_pc  = seq_pc + {{(PC_W-18){instr[15]}}, instr[15:0], 2'b00};

    // R2: the PC holds while advance is low
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(pc));

    // R2: no link write without advance
    a_r2_no_link: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> advance);

    // R3: plain opcodes step by one word
    a_r3_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && op != 6'h00 && op != 6'h02 && op != 6'h03 &&
         op != 6'h04 && op != 6'h05) |=> pc == $past(seq_pc));

    // R4: equal operands take a branch-if-equal
    a_r4_beq: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && op == 6'h04 && rs_val == rt_val) |=> pc == $past(br_pc));

    // R5: equal operands do not take a branch-if-different
    a_r5_bne_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && op == 6'h05 && rs_val == rt_val) |=> pc == $past(seq_pc));

    // R8: a call raises the link write carrying PC+4 to register 31
    a_r8_link: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && op == 6'h03) |-> (link_we && link_idx == 5'd31 && link_data == seq_pc));

    // R9: register jump loads rs_val
    a_r9_jreg: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && op == 6'h00 && fn == 6'h08) |=> pc == $past(rs_val));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .instr     (instr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .pc        (pc),
    .link_we   (link_we),
    .link_idx  (link_idx),
    .link_data (link_data)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] model_pc = 32'h0;

    always #10 clk = ~clk;

    npc_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .instr     (instr),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .pc        (pc),
        .link_we   (link_we),
        .link_idx  (link_idx),
        .link_data (link_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [25:0] rest);
        return {op, rest};
    endfunction

    // Driver: apply one instruction, check combinational link outputs, queue the expected PC
    task automatic step(input bit adv, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        logic [31:0] nxt;
        logic [31:0] inc;
        logic [5:0]  op;
        bit          is_call;
        @(negedge clk);
        advance = adv;
        instr   = ins;
        rs_val  = a;
        rt_val  = b;
        #2;
        op  = ins[31:26];
        inc = model_pc + 32'd4;
        is_call = adv && (op == 6'h03);
        nxt = inc;
        if (!adv) nxt = model_pc;
        else if (op == 6'h02 || op == 6'h03) nxt = {inc[31:28], ins[25:0], 2'b00};
        else if (op == 6'h04 && a == b) nxt = inc + {{14{ins[15]}}, ins[15:0], 2'b00};
        else if (op == 6'h05 && a != b) nxt = inc + {{14{ins[15]}}, ins[15:0], 2'b00};
        else if (op == 6'h00 && ins[5:0] == 6'h08) nxt = a;
        check(link_we == is_call, {tag, " link_we"}, {31'h0, link_we}, {31'h0, is_call});
        if (is_call) begin
            check(link_idx == 5'd31, {tag, " link_idx"}, {27'h0, link_idx}, 32'd31);
            check(link_data == inc, {tag, " link_data"}, link_data, inc);
        end
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
        model_pc = nxt;
    endtask

    // Monitor: compare each registered PC against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(pc == e, {t, " pc"}, pc, e);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value while held in reset
        check(pc == 32'h0, "R1 in reset", pc, 32'h0);
        rst_n = 1'b1;
        #2;
        check(pc == 32'h0, "R1 after release", pc, 32'h0);
        check(link_we == 1'b0, "R1 link_we", {31'h0, link_we}, 32'h0);

        // R2: call and jump without advance change nothing
        step(1'b0, mk_i(6'h03, 26'h0000040), 32'h0, 32'h0, "R2 call held");
        step(1'b0, mk_i(6'h02, 26'h0000100), 32'h0, 32'h0, "R2 jump held");
        // R3: immediate-type opcode is sequential
        step(1'b1, mk_i(6'h08, 26'h0), 32'h0, 32'h0, "R3 seq");
        step(1'b1, mk_i(6'h23, 26'h0), 32'h0, 32'h0, "R3 seq load");
        // R10: register op with other function is sequential
        step(1'b1, mk_i(6'h00, 26'h0000020), 32'h0, 32'h0, "R10 alu");
        // R4: branch-if-equal taken and not taken
        step(1'b1, mk_i(6'h04, 26'h0000003), 32'h55, 32'h55, "R4 beq taken");
        step(1'b1, mk_i(6'h04, 26'h0000003), 32'h55, 32'h56, "R4 beq fall");
        // R5 and R6: backward branch-if-different, then equal operands fall through
        step(1'b1, mk_i(6'h05, 26'h000FFFE), 32'h1, 32'h2, "R5 R6 bne back");
        step(1'b1, mk_i(6'h05, 26'h000FFFE), 32'h7, 32'h7, "R5 bne fall");
        // R7: jump
        step(1'b1, mk_i(6'h02, 26'h0000100), 32'h0, 32'h0, "R7 jump");
        // R8: call writes the link
        step(1'b1, mk_i(6'h03, 26'h0000040), 32'h0, 32'h0, "R8 call");
        // R9: register jump to the last word of a region
        step(1'b1, mk_i(6'h00, 26'h0000008), 32'h0FFFFFFC, 32'h0, "R9 jreg");
        // R11: jump region comes from PC+4
        step(1'b1, mk_i(6'h02, 26'h0000010), 32'h0, 32'h0, "R11 region");
        // R6: most negative offset
        step(1'b1, mk_i(6'h04, 26'h0008000), 32'h9, 32'h9, "R6 min offset");
        // R2: hold again at a high address
        step(1'b0, mk_i(6'h00, 26'h0000008), 32'h12345678, 32'h0, "R2 jreg held");
        // R9: arbitrary full-width register value
        step(1'b1, mk_i(6'h00, 26'h0000008), 32'hCAFE0010, 32'h0, "R9 jreg full");
        // R8: call from a high region keeps upper bits
        step(1'b1, mk_i(6'h03, 26'h3FFFFFF), 32'h0, 32'h0, "R8 call high");

        @(negedge clk);
        advance = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule